// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Operand Capture

This block holds a small set of waiting operations in front of one class of execution unit. Issue logic hands it an operation whose two source operands each arrive either as a value or as the tag of the station that will produce the value. A tag of zero means the value is already present. A nonzero tag means the operand is still pending. The pool watches a shared result broadcast bus, which carries a data word and the tag of its producer. Any pending operand whose tag matches the broadcast takes the data and clears its tag.

An operation whose two tags are both zero is offered to the execution unit. When that unit later broadcasts a result under the station's own tag, the station is released. Station `i` owns tag `TAG_BASE + i`. `issue_ready` tells issue logic whether a station is free. When it is low, issue must stall on a structural hazard.

Both data interfaces are valid/ready. An issue is accepted on a cycle where `issue_valid` and `issue_ready` are both high. `issue_ready` depends only on station occupancy, never on `issue_valid`. A dispatch is taken on a cycle where `disp_valid` and `disp_ready` are both high. While `disp_valid` is high and `disp_ready` is low, the offered operation and its tag stay unchanged.

Top module: `rsp_pool`

## Requirements
- R1: After reset, every station is free: `issue_ready` is 1, `issue_tag` equals `TAG_BASE`, and `disp_valid` is 0.
- R2: `issue_ready` is 0 when every station is occupied. An issue presented while `issue_ready` is 0 is dropped and never reaches dispatch.
- R3: An operation issued with both tags zero is offered for dispatch on the next cycle. It carries the issued op code, the first operand on `disp_a`, the second on `disp_b`, and the station tag on `disp_tag`.
- R4: A station is not offered for dispatch while either of its operand tags is nonzero.
- R5: When `cdb_valid` is high and `cdb_tag` equals a pending operand tag, that operand takes `cdb_data` and becomes present. This holds for both operands independently.
- R6: If an operand's producer broadcasts in the same cycle the operation is issued, the station takes the broadcast data in place of the tag.
- R7: Among ready stations, the lowest-indexed one is offered. At most one dispatch is taken per cycle.
- R8: A dispatched station is never offered again. An offer not yet taken stays stable (same tag, op and operands) until `disp_ready` is high, even if a lower-indexed station becomes ready.
- R9: A broadcast carrying the tag of a dispatched station frees that station on the next cycle. `issue_tag` always names the lowest-indexed free station, which takes the next accepted issue.
- R10: A broadcast whose tag matches no pending operand changes no stored operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue request |
| issue_ready | output | 1 | A station is free (low means structural hazard) |
| issue_tag | output | TAG_W | Tag of the station that takes the next issue |
| issue_op | input | OP_W | Operation code |
| issue_vj | input | DATA_W | First operand value (used when `issue_qj` is 0) |
| issue_qj | input | TAG_W | First operand producer tag, 0 = present |
| issue_vk | input | DATA_W | Second operand value (used when `issue_qk` is 0) |
| issue_qk | input | TAG_W | Second operand producer tag, 0 = present |
| disp_valid | output | 1 | An operation is offered to the execution unit |
| disp_ready | input | 1 | Execution unit accepts the offer |
| disp_op | output | OP_W | Offered op code |
| disp_a | output | DATA_W | Offered first operand |
| disp_b | output | DATA_W | Offered second operand |
| disp_tag | output | TAG_W | Tag under which the result must be broadcast |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Producer tag of the broadcast |
| cdb_data | input | DATA_W | Broadcast data word |

## Verification
The assertions assume the result bus only carries a pool-owned tag for a station that has already been dispatched. They also assume a producer tag never refers to the station receiving the operation. The bench keeps to these rules by using external tags (7 to 10) for pending operands. It broadcasts a pool tag only after the scoreboard has seen that station dispatch. Back-pressure is applied only by holding `disp_ready` low, and the bench never withdraws an offer.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  // Life cycle of one reservation station.
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2
  } st_state_e;

endpackage

// File: rtl/rsp_pick.sv
// Lowest-index one-hot picker.
module rsp_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt[i]    = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[N];
endmodule

// File: rtl/rsp_operand.sv
// One operand slot: a value plus the tag of its producer (0 = present).
module rsp_operand #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] in_v,
  input  logic [TAG_W-1:0]  in_q,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic [DATA_W-1:0] val,
  output logic [TAG_W-1:0]  tag
);
  logic in_hit;
  logic snoop_hit;

  assign in_hit    = cdb_valid && (in_q != '0) && (cdb_tag == in_q);
  assign snoop_hit = cdb_valid && (tag  != '0) && (cdb_tag == tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
      tag <= '0;
    end else if (load) begin
      val <= in_hit ? cdb_data : in_v;
      tag <= in_hit ? '0 : in_q;
    end else if (snoop_hit) begin
      val <= cdb_data;
      tag <= '0;
    end
  end
endmodule

// File: rtl/rsp_station.sv
// One reservation station: op, two operand slots and a state.
module rsp_station
  import rsp_pkg::*;
#(
  parameter int             DATA_W = 32,
  parameter int             TAG_W  = 4,
  parameter int             OP_W   = 4,
  parameter logic [TAG_W-1:0] MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vk,
  input  logic [TAG_W-1:0]  iss_qk,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              launch,
  output st_state_e         state,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk
);
  logic [TAG_W-1:0] qj;
  logic [TAG_W-1:0] qk;
  logic             own_bcast;

  rsp_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opj (
    .clk(clk), .rst_n(rst_n), .load(alloc), .in_v(iss_vj), .in_q(iss_qj),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .val(vj), .tag(qj)
  );

  rsp_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opk (
    .clk(clk), .rst_n(rst_n), .load(alloc), .in_v(iss_vk), .in_q(iss_qk),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .val(vk), .tag(qk)
  );

  assign own_bcast = cdb_valid && (cdb_tag == MY_TAG);
  assign ready     = (state == ST_WAIT) && (qj == '0) && (qk == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_FREE;
      op    <= '0;
    end else begin
      case (state)
        ST_FREE: if (alloc) begin
          state <= ST_WAIT;
          op    <= iss_op;
        end
        ST_WAIT: if (launch) state <= ST_EXEC;
        ST_EXEC: if (own_bcast) state <= ST_FREE;
        default: state <= ST_FREE;
      endcase
    end
  end
endmodule

// File: rtl/rsp_pool.sv
module rsp_pool
  import rsp_pkg::*;
#(
  parameter int NUM_ST   = 3,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  parameter int OP_W     = 4,
  parameter int TAG_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  output logic [TAG_W-1:0]  issue_tag,
  input  logic [OP_W-1:0]   issue_op,
  input  logic [DATA_W-1:0] issue_vj,
  input  logic [TAG_W-1:0]  issue_qj,
  input  logic [DATA_W-1:0] issue_vk,
  input  logic [TAG_W-1:0]  issue_qk,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output logic [TAG_W-1:0]  disp_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data
);
  localparam int TAG_LAST = TAG_BASE + NUM_ST - 1;

  logic [NUM_ST-1:0] busy_vec;
  logic [NUM_ST-1:0] exec_vec;
  logic [NUM_ST-1:0] rdy_vec;
  logic [NUM_ST-1:0] free_gnt;
  logic [NUM_ST-1:0] rdy_gnt;
  logic [NUM_ST-1:0] alloc_vec;
  logic [NUM_ST-1:0] sel_vec;
  logic [NUM_ST-1:0] hold_vec_q;
  logic [NUM_ST-1:0] launch_vec;
  logic              any_free;
  logic              any_rdy;

  st_state_e         st_state [NUM_ST];
  logic [OP_W-1:0]   op_arr   [NUM_ST];
  logic [DATA_W-1:0] vj_arr   [NUM_ST];
  logic [DATA_W-1:0] vk_arr   [NUM_ST];

  rsp_pick #(.N(NUM_ST)) u_free_pick (.req(~busy_vec), .gnt(free_gnt), .any(any_free));
  rsp_pick #(.N(NUM_ST)) u_rdy_pick  (.req(rdy_vec),   .gnt(rdy_gnt),  .any(any_rdy));

  assign issue_ready = any_free;
  assign alloc_vec   = free_gnt & {NUM_ST{issue_valid}};

  // An offer not taken is pinned until accepted.
  assign sel_vec    = (|hold_vec_q) ? hold_vec_q : rdy_gnt;
  assign disp_valid = |sel_vec;
  assign launch_vec = sel_vec & {NUM_ST{disp_ready}};

  always_ff @(posedge clk) begin
    if (!rst_n) hold_vec_q <= '0;
    else        hold_vec_q <= disp_ready ? '0 : sel_vec;
  end

  for (genvar i = 0; i < NUM_ST; i++) begin : g_st
    localparam logic [TAG_W-1:0] ST_TAG = TAG_W'(TAG_BASE + i);

    rsp_station #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .MY_TAG(ST_TAG)
    ) u_st (
      .clk(clk), .rst_n(rst_n), .alloc(alloc_vec[i]),
      .iss_op(issue_op), .iss_vj(issue_vj), .iss_qj(issue_qj),
      .iss_vk(issue_vk), .iss_qk(issue_qk),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .launch(launch_vec[i]), .state(st_state[i]), .ready(rdy_vec[i]),
      .op(op_arr[i]), .vj(vj_arr[i]), .vk(vk_arr[i])
    );

    assign busy_vec[i] = (st_state[i] != ST_FREE);
    assign exec_vec[i] = (st_state[i] == ST_EXEC);
  end

  always_comb begin
    issue_tag = '0;
    disp_op   = '0;
    disp_a    = '0;
    disp_b    = '0;
    disp_tag  = '0;
    for (int i = 0; i < NUM_ST; i++) begin
      if (free_gnt[i]) issue_tag = TAG_W'(TAG_BASE + i);
      if (sel_vec[i]) begin
        disp_op  = disp_op | op_arr[i];
        disp_a   = disp_a  | vj_arr[i];
        disp_b   = disp_b  | vk_arr[i];
        disp_tag = disp_tag | TAG_W'(TAG_BASE + i);
      end
    end
  end

  // Elaboration-time guard on the tag space.
  initial begin
    if (TAG_BASE < 1 || TAG_LAST >= (1 << TAG_W))
      $error("rsp_pool: station tags do not fit TAG_W");
  end
endmodule

// File: rtl/rsp_pool_chk.sv
module rsp_pool_chk #(
  parameter int NUM_ST   = 3,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 4,
  parameter int OP_W     = 4,
  parameter int TAG_BASE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic              issue_ready,
  input logic [TAG_W-1:0]  issue_tag,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic [OP_W-1:0]   disp_op,
  input logic [DATA_W-1:0] disp_a,
  input logic [DATA_W-1:0] disp_b,
  input logic [TAG_W-1:0]  disp_tag,
  input logic              cdb_valid,
  input logic [TAG_W-1:0]  cdb_tag,
  input logic [NUM_ST-1:0] busy_vec,
  input logic [NUM_ST-1:0] exec_vec,
  input logic [NUM_ST-1:0] launch_vec
);
  logic [NUM_ST-1:0] tag_match;

  always_comb begin
    for (int i = 0; i < NUM_ST; i++)
      tag_match[i] = (issue_tag == TAG_W'(TAG_BASE + i));
  end

  // R8
  offer_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid && $stable(disp_tag) &&
      $stable(disp_op) && $stable(disp_a) && $stable(disp_b));

  // R7
  one_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(launch_vec));

  // R9
  issue_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_ready |=> (busy_vec & $past(tag_match)) != '0);

  for (genvar i = 0; i < NUM_ST; i++) begin : g_chk
    // R9
    free_on_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cdb_valid && (cdb_tag == TAG_W'(TAG_BASE + i)) && exec_vec[i] |=> !busy_vec[i]);

    // R8
    no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exec_vec[i] |-> !launch_vec[i]);
  end
endmodule

bind rsp_pool rsp_pool_chk #(
  .NUM_ST(NUM_ST), .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .TAG_BASE(TAG_BASE)
) u_chk (.*);

// File: tb/rsp_pool_test.sv
module rsp_pool_test;
  localparam int DW = 32;
  localparam int TW = 4;
  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_valid = 1'b0;
  logic          issue_ready;
  logic [TW-1:0] issue_tag;
  logic [OW-1:0] issue_op = '0;
  logic [DW-1:0] issue_vj = '0;
  logic [TW-1:0] issue_qj = '0;
  logic [DW-1:0] issue_vk = '0;
  logic [TW-1:0] issue_qk = '0;
  logic          disp_valid;
  logic          disp_ready = 1'b1;
  logic [OW-1:0] disp_op;
  logic [DW-1:0] disp_a;
  logic [DW-1:0] disp_b;
  logic [TW-1:0] disp_tag;
  logic          cdb_valid = 1'b0;
  logic [TW-1:0] cdb_tag = '0;
  logic [DW-1:0] cdb_data = '0;

  typedef struct packed {
    logic [OW-1:0] op;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic [TW-1:0] tag;
  } item_t;

  item_t exp_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;

  always #10 clk = ~clk;

  rsp_pool uut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input int op, input int a, input int b, input int tag);
    item_t it;
    it.op = OW'(op); it.a = DW'(a); it.b = DW'(b); it.tag = TW'(tag);
    exp_q.push_back(it);
  endtask

  task automatic do_issue(input int op, input int vj, input int qj, input int vk, input int qk,
                          input bit bv, input int bt, input int bd);
    issue_op = OW'(op); issue_vj = DW'(vj); issue_qj = TW'(qj);
    issue_vk = DW'(vk); issue_qk = TW'(qk); issue_valid = 1'b1;
    cdb_valid = bv; cdb_tag = TW'(bt); cdb_data = DW'(bd);
    tick();
    issue_valid = 1'b0; cdb_valid = 1'b0;
  endtask

  task automatic bcast(input int t, input int d);
    cdb_valid = 1'b1; cdb_tag = TW'(t); cdb_data = DW'(d);
    tick();
    cdb_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Scoreboard monitor: samples just before each rising edge.
  always @(negedge clk) begin
    #8;
    if (rst_n && disp_valid && disp_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected dispatch", longint'(disp_tag), 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk(disp_tag == e.tag, "R7 dispatch tag", longint'(disp_tag), longint'(e.tag));
        chk(disp_op == e.op,   "R3 dispatch op",  longint'(disp_op),  longint'(e.op));
        chk(disp_a == e.a,     "R5 dispatch a",   longint'(disp_a),   longint'(e.a));
        chk(disp_b == e.b,     "R5 dispatch b",   longint'(disp_b),   longint'(e.b));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1
    chk(issue_ready == 1'b1, "R1 issue_ready", longint'(issue_ready), 1);
    chk(issue_tag == 4'd1,   "R1 issue_tag",   longint'(issue_tag), 1);
    chk(disp_valid == 1'b0,  "R1 disp_valid",  longint'(disp_valid), 0);

    // R3: operands present at issue
    push(1, 10, 20, 1);
    do_issue(1, 10, 0, 20, 0, 0, 0, 0);
    chk(issue_tag == 4'd2, "R9 next free tag", longint'(issue_tag), 2);
    tick();
    chk(disp_valid == 1'b0, "R8 no re-offer", longint'(disp_valid), 0);
    bcast(1, 0);
    chk(issue_tag == 4'd1, "R9 freed on broadcast", longint'(issue_tag), 1);

    // R4, R5, R10: both operands pending
    do_issue(2, 0, 9, 0, 10, 0, 0, 0);
    chk(disp_valid == 1'b0, "R4 waiting", longint'(disp_valid), 0);
    bcast(8, 999);
    chk(disp_valid == 1'b0, "R10 foreign tag", longint'(disp_valid), 0);
    bcast(9, 77);
    chk(disp_valid == 1'b0, "R4 one operand still pending", longint'(disp_valid), 0);
    push(2, 77, 66, 1);
    bcast(10, 66);
    tick();
    bcast(1, 0);

    // R6: producer broadcasts in the issue cycle
    push(3, 55, 3, 1);
    do_issue(3, 0, 7, 3, 0, 1, 7, 55);
    tick();
    bcast(1, 0);

    // R2, R7: fill the pool under back-pressure
    disp_ready = 1'b0;
    do_issue(4, 1, 0, 1, 0, 0, 0, 0);
    do_issue(5, 2, 0, 2, 0, 0, 0, 0);
    do_issue(6, 3, 0, 3, 0, 0, 0, 0);
    chk(issue_ready == 1'b0, "R2 full", longint'(issue_ready), 0);
    chk(disp_tag == 4'd1,    "R7 lowest offered", longint'(disp_tag), 1);
    do_issue(7, 9, 0, 9, 0, 0, 0, 0);
    chk(issue_ready == 1'b0, "R2 still full", longint'(issue_ready), 0);
    push(4, 1, 1, 1);
    push(5, 2, 2, 2);
    push(6, 3, 3, 3);
    disp_ready = 1'b1;
    tick(); tick(); tick();
    chk(disp_valid == 1'b0, "R7 one per cycle drained", longint'(disp_valid), 0);
    bcast(1, 0); bcast(2, 0); bcast(3, 0);
    chk(issue_ready == 1'b1, "R9 all freed", longint'(issue_ready), 1);
    tick();
    chk(disp_valid == 1'b0, "R2 dropped issue absent", longint'(disp_valid), 0);

    // R8: held offer survives a lower station becoming ready
    disp_ready = 1'b0;
    do_issue(8, 0, 9, 1, 0, 0, 0, 0);
    do_issue(9, 4, 0, 4, 0, 0, 0, 0);
    chk(disp_tag == 4'd2, "R7 only ready station", longint'(disp_tag), 2);
    bcast(9, 30);
    chk(disp_tag == 4'd2, "R8 held offer", longint'(disp_tag), 2);
    push(9, 4, 4, 2);
    push(8, 30, 1, 1);
    disp_ready = 1'b1;
    tick(); tick();
    bcast(1, 0); bcast(2, 0);
    chk(issue_ready == 1'b1, "R9 pool free", longint'(issue_ready), 1);

    tick();
    chk(exp_q.size() == 0, "R3 all dispatched", longint'(exp_q.size()), 0);
    done = 1;
    finish_run();
  end
endmodule